// File: doc/BRIEF.md
# Skipping Up Counter

A synchronous up counter, four bits wide by default, with clear, parallel load and count enable. A separate skip input can change on any clock edge. When the count advances and the next value would equal the skip input, the counter jumps ahead by two instead of one. Counting therefore never lands on the skip value.

Clear overrides everything else and load overrides counting. A loaded value is kept even when it equals the skip value, because the skip applies only to increments. Arithmetic wraps around at the top of the range. The block has no asynchronous reset. Clear is the only way to initialise it.

Top module: `skip_counter`

## Requirements
- R1: When clr is high at a rising clock edge, cnt becomes 0 on that edge, whatever load and en are.
- R2: When load is high and clr is low at a rising edge, cnt takes ld_val on that edge, whatever en is.
- R3: When en is high and clr and load are low, cnt becomes (cnt+1) mod 16 if that value differs from the skip input sampled at the same edge.
- R4: When en is high and clr and load are low, and (cnt+1) mod 16 equals the skip input at that edge, cnt becomes (cnt+2) mod 16. Examples: 14 with skip 15 gives 0, and 15 with skip 0 gives 1.
- R5: When clr, load and en are all low, cnt keeps its value.
- R6: A loaded value equal to the skip input is held in cnt. The next enabled edge then advances by the rule in R3 and R4.
- R7: An enabled increment never produces a cnt equal to the skip input sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear to zero, highest priority |
| load | input | 1 | Synchronous parallel load |
| en | input | 1 | Count enable |
| ld_val | input | W | Value taken on load |
| skip | input | W | Value that counting steps over |
| cnt | output | W | Current count |

## Verification
The count is the only state, so any wrong next-state choice appears on cnt right after the edge that caused it. The error then carries forward into every later cycle until clear or load replaces it. The bench sweeps every count against every skip value under enable, and every load value against every skip value. It also covers the two wrap-around cases, because a comparator that ignores the carry would only fail there.

// File: rtl/skip_counter.sv
module skip_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         load,
  input  logic         en,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] skip,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  logic         hit;
  logic [W-1:0] step;

  assign hit  = (cnt == skip - ONE);
  assign step = hit ? TWO : ONE;

  always_ff @(posedge clk) begin
    if (clr)       cnt <= '0;
    else if (load) cnt <= ld_val;
    else if (en)   cnt <= cnt + step;
  end
endmodule

module skip_counter_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         clr,
  input logic         load,
  input logic         en,
  input logic [W-1:0] ld_val,
  input logic [W-1:0] skip,
  input logic [W-1:0] cnt
);
  logic started = 1'b0;
  always_ff @(posedge clk) if (clr) started <= 1'b1;

  assert_clear_R1: assert property (@(posedge clk) disable iff (!started)
    clr |=> cnt == '0);
  assert_load_R2: assert property (@(posedge clk) disable iff (!started)
    (!clr && load) |=> cnt == $past(ld_val));
  assert_step_R3_R4: assert property (@(posedge clk) disable iff (!started)
    (!clr && !load && en) |=>
      (cnt == W'($past(cnt) + W'(1)) || cnt == W'($past(cnt) + W'(2))));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!started)
    (!clr && !load && !en) |=> $stable(cnt));
  assert_no_land_R7: assert property (@(posedge clk) disable iff (!started)
    (!clr && !load && en) |=> cnt != $past(skip));
endmodule

bind skip_counter skip_counter_chk #(.W(W)) u_chk (.*);

// File: tb/skip_counter_bench.sv
module skip_counter_bench;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic clk = 1'b0;
  logic clr = 1'b0, load = 1'b0, en = 1'b0;
  logic [W-1:0] ld_val = '0, skip = '0;
  logic [W-1:0] cnt;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  skip_counter #(.W(W)) u_skip_counter (.*);

  task automatic check(string req, logic [W-1:0] exp);
    checks++;
    if (cnt !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, cnt, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic do_load(logic [W-1:0] v);
    clr = 0; load = 1; en = 0; ld_val = v;
    tick();
    load = 0;
  endtask

  function automatic logic [W-1:0] nxt(logic [W-1:0] c, logic [W-1:0] s);
    logic [W-1:0] p = c + W'(1);
    return (p == s) ? W'(c + W'(2)) : p;
  endfunction

  initial begin
    #2;
    clr = 1; load = 1; en = 1; ld_val = 4'd9;
    tick();
    check("R1", '0);
    clr = 0; load = 0; en = 0;

    for (int v = 0; v < N; v++) begin
      clr = 0; load = 1; en = 1; ld_val = W'(v);
      tick();
      check("R2", W'(v));
    end
    load = 0;

    for (int c = 0; c < N; c++)
      for (int s = 0; s < N; s++) begin
        do_load(W'(c));
        skip = W'(s); en = 1;
        tick();
        en = 0;
        if (W'(c + 1) == W'(s)) check("R4", nxt(W'(c), W'(s)));
        else check("R3", nxt(W'(c), W'(s)));
        checks++;
        if (cnt === W'(s)) begin
          errors++;
          $display("FAIL R7 actual %0d expected not %0d", cnt, s);
        end
      end

    do_load(4'd14); skip = 4'd15; en = 1; tick(); en = 0; check("R4", 4'd0);
    do_load(4'd15); skip = 4'd0;  en = 1; tick(); en = 0; check("R4", 4'd1);

    do_load(4'd7); skip = 4'd8;
    for (int k = 0; k < 4; k++) begin
      tick();
      check("R5", 4'd7);
    end

    for (int s = 0; s < N; s++) begin
      skip = W'(s);
      do_load(W'(s));
      check("R6", W'(s));
      en = 1; tick(); en = 0;
      check("R6", nxt(W'(s), W'(s)));
    end

    do_load(4'd0);
    begin
      logic [W-1:0] m = '0;
      en = 1;
      for (int k = 0; k < 40; k++) begin
        skip = W'((k * 5 + 3) % N);
        m = nxt(m, skip);
        tick();
        check("R3", m);
      end
      en = 0;
    end

    do_load(4'd11); en = 1; clr = 1; tick(); clr = 0; en = 0;
    check("R1", '0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule